// File: doc/BRIEF.md
# Chainable Triple Integer ALU Cluster

The cluster holds three small 32-bit integer ALUs for a low-power compute node running database and symbolic code. A configuration word is presented every cycle. It holds three opcodes, three enable bits and two operand-source selects per stage. With this word, the three ALUs can run side by side on unrelated operands. They can also be wired into a combinational cascade, where stage 0 feeds stage 1 and stage 1 feeds stage 2. A single-cycle expression such as `s ^ ((a << 3) & b)` is therefore possible.

Each stage has a result register and a valid flag. A stall input, raised while a neighbouring multiplier is busy, freezes the result registers and drops every valid flag for as long as it is high. Register file, decode and the multiplier stay outside the block.

Top module: `alu3_cluster`

## Requirements
- R1: While reset is low, and in the first cycle after it, every valid flag is 0 and every result is 0.
- R2: With stall low, an enabled stage shows its valid flag high in the cycle after the edge, and its result equals its operation applied to its selected operands. Each stage does this independently of the other stages.
- R3: Opcode encodings are: 0 pass operand A, 1 A+B, 2 A-B, 3 A AND B, 4 A OR B, 5 A XOR B, 6 A shifted left by B[4:0], 7 A shifted right logically by B[4:0]. Add and subtract wrap modulo 2^32.
- R4: Source select encodings are: 0 register operand, 1 immediate, 2 previous stage's combinational result, 3 zero. For stage 0, select 2 yields zero.
- R5: Cascading is combinational. A stage 2 that chains from stage 1, which in turn chains from stage 0, registers the three-operation result at the same edge as the other stages.
- R6: With stall low, a disabled stage has its valid flag low after the edge, and its result register keeps its previous value.
- R7: While stall is high, all valid flags are low after the edge and all result registers keep their values. A configuration presented during stall leaves no trace.
- R8: A chained stage uses the previous stage's computed value even when that previous stage is disabled.
- R9: Stage sources are bound to their own lane: stage k reads register operand k and immediate k only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Freeze request from the multiplier |
| cfg_en_i | input | 3 | Per-stage enable, bit k for stage k |
| cfg_op_i | input | 9 | Opcodes, stage k at bits 3k+2:3k |
| cfg_sel_a_i | input | 6 | Operand A source, stage k at bits 2k+1:2k |
| cfg_sel_b_i | input | 6 | Operand B source, stage k at bits 2k+1:2k |
| opa_i | input | 96 | Register operand A, stage k at bits 32k+31:32k |
| opb_i | input | 96 | Register operand B, stage k at bits 32k+31:32k |
| imm_i | input | 96 | Immediate, stage k at bits 32k+31:32k |
| res_o | output | 96 | Registered results, stage k at bits 32k+31:32k |
| vld_o | output | 3 | Registered valid flags |

## Verification
Each opcode is driven with register and immediate operands, including values that wrap and shift amounts above 31. This separates correct wrapping and 5-bit truncation from sign or width errors. A full three-deep cascade is compared against the directly computed expression. A chain fed by a disabled stage distinguishes computed-value forwarding from register forwarding. Random mixes of enables, selects and stalls then catch crossed lanes, wrong select decoding and leakage of configuration through a stall.

// File: rtl/alu3_pkg.sv
`timescale 1ns/1ps
package alu3_pkg;
    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_SHL  = 3'd6,
        OP_SHR  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_REG  = 2'd0,
        SRC_IMM  = 2'd1,
        SRC_PREV = 2'd2,
        SRC_ZERO = 2'd3
    } src_sel_e;

    localparam int OP_W  = 3;
    localparam int SEL_W = 2;
endpackage

// File: rtl/alu3_opsel.sv
`timescale 1ns/1ps
module alu3_opsel
    import alu3_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [W-1:0]     reg_i,
    input  logic [W-1:0]     imm_i,
    input  logic [W-1:0]     prev_i,
    output logic [W-1:0]     val_o
);
    always_comb begin
        case (src_sel_e'(sel_i))
            SRC_REG:  val_o = reg_i;
            SRC_IMM:  val_o = imm_i;
            SRC_PREV: val_o = prev_i;
            default:  val_o = '0;
        endcase
    end
endmodule

// File: rtl/alu3_core.sv
`timescale 1ns/1ps
module alu3_core
    import alu3_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    y_o
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] shamt;
    assign shamt = b_i[SHW-1:0];

    always_comb begin
        case (alu_op_e'(op_i))
            OP_PASS: y_o = a_i;
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            OP_SHL:  y_o = a_i << shamt;
            default: y_o = a_i >> shamt;
        endcase
    end
endmodule

// File: rtl/alu3_cluster.sv
`timescale 1ns/1ps
module alu3_cluster
    import alu3_pkg::*;
#(
    parameter int W       = 32,
    parameter int NUM_ALU = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stall_i,
    input  logic [NUM_ALU-1:0]       cfg_en_i,
    input  logic [NUM_ALU*OP_W-1:0]  cfg_op_i,
    input  logic [NUM_ALU*SEL_W-1:0] cfg_sel_a_i,
    input  logic [NUM_ALU*SEL_W-1:0] cfg_sel_b_i,
    input  logic [NUM_ALU*W-1:0]     opa_i,
    input  logic [NUM_ALU*W-1:0]     opb_i,
    input  logic [NUM_ALU*W-1:0]     imm_i,
    output logic [NUM_ALU*W-1:0]     res_o,
    output logic [NUM_ALU-1:0]       vld_o
);
    typedef struct packed {
        logic [NUM_ALU-1:0][W-1:0] res;
        logic [NUM_ALU-1:0]        vld;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] stage_y [NUM_ALU];
    logic [W-1:0] prev_v  [NUM_ALU];

    for (genvar k = 0; k < NUM_ALU; k++) begin : g_stage
        logic [W-1:0] a_v, b_v;

        if (k == 0) begin : g_head
            assign prev_v[k] = '0;
        end else begin : g_link
            assign prev_v[k] = stage_y[k-1];
        end

        alu3_opsel #(.W(W)) u_sel_a (
            .sel_i  (cfg_sel_a_i[SEL_W*k +: SEL_W]),
            .reg_i  (opa_i[W*k +: W]),
            .imm_i  (imm_i[W*k +: W]),
            .prev_i (prev_v[k]),
            .val_o  (a_v)
        );

        alu3_opsel #(.W(W)) u_sel_b (
            .sel_i  (cfg_sel_b_i[SEL_W*k +: SEL_W]),
            .reg_i  (opb_i[W*k +: W]),
            .imm_i  (imm_i[W*k +: W]),
            .prev_i (prev_v[k]),
            .val_o  (b_v)
        );

        alu3_core #(.W(W)) u_core (
            .op_i (cfg_op_i[OP_W*k +: OP_W]),
            .a_i  (a_v),
            .b_i  (b_v),
            .y_o  (stage_y[k])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_ALU; k++) begin
            if (stall_i) begin
                st_d.vld[k] = 1'b0;
            end else begin
                st_d.vld[k] = cfg_en_i[k];
                if (cfg_en_i[k]) begin
                    st_d.res[k] = stage_y[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = st_q.res;
    assign vld_o = st_q.vld;
endmodule

// File: rtl/alu3_cluster_chk.sv
`timescale 1ns/1ps
module alu3_cluster_chk
    import alu3_pkg::*;
#(
    parameter int W       = 32,
    parameter int NUM_ALU = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     stall_i,
    input logic [NUM_ALU-1:0]       cfg_en_i,
    input logic [NUM_ALU*OP_W-1:0]  cfg_op_i,
    input logic [NUM_ALU*SEL_W-1:0] cfg_sel_a_i,
    input logic [NUM_ALU*W-1:0]     res_o,
    input logic [NUM_ALU-1:0]       vld_o
);
    a_r7_stall_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> (vld_o == '0));

    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable(res_o));

    for (genvar k = 0; k < NUM_ALU; k++) begin : g_chk
        a_r2_valid_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
            (!stall_i && cfg_en_i[k]) |=> vld_o[k]);

        a_r6_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!stall_i && !cfg_en_i[k]) |=> (!vld_o[k] && $stable(res_o[W*k +: W])));

        if (k > 0) begin : g_link
            a_r5_chain_pass: assert property (@(posedge clk) disable iff (!rst_n)
                (!stall_i && cfg_en_i[k] && cfg_en_i[k-1]
                 && cfg_op_i[OP_W*k +: OP_W] == OP_W'(OP_PASS)
                 && cfg_sel_a_i[SEL_W*k +: SEL_W] == SEL_W'(SRC_PREV))
                |=> (res_o[W*k +: W] == res_o[W*(k-1) +: W]));
        end
    end
endmodule

bind alu3_cluster alu3_cluster_chk #(.W(W), .NUM_ALU(NUM_ALU)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_i     (stall_i),
    .cfg_en_i    (cfg_en_i),
    .cfg_op_i    (cfg_op_i),
    .cfg_sel_a_i (cfg_sel_a_i),
    .res_o       (res_o),
    .vld_o       (vld_o)
);

// File: tb/tb_alu3_cluster.sv
`timescale 1ns/1ps
module tb_alu3_cluster;
    localparam int W = 32;
    localparam int N = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall_i = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0]   t_op [N];
    logic [1:0]   t_sa [N];
    logic [1:0]   t_sb [N];
    logic [W-1:0] t_ra [N];
    logic [W-1:0] t_rb [N];
    logic [W-1:0] t_im [N];
    logic [N-1:0] t_en;

    logic [N*3-1:0] cfg_op_i;
    logic [N*2-1:0] cfg_sel_a_i, cfg_sel_b_i;
    logic [N*W-1:0] opa_i, opb_i, imm_i, res_o;
    logic [N-1:0]   vld_o;

    assign cfg_op_i    = {t_op[2], t_op[1], t_op[0]};
    assign cfg_sel_a_i = {t_sa[2], t_sa[1], t_sa[0]};
    assign cfg_sel_b_i = {t_sb[2], t_sb[1], t_sb[0]};
    assign opa_i       = {t_ra[2], t_ra[1], t_ra[0]};
    assign opb_i       = {t_rb[2], t_rb[1], t_rb[0]};
    assign imm_i       = {t_im[2], t_im[1], t_im[0]};

    alu3_cluster #(.W(W), .NUM_ALU(N)) dut (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .cfg_en_i(t_en),
        .cfg_op_i(cfg_op_i), .cfg_sel_a_i(cfg_sel_a_i), .cfg_sel_b_i(cfg_sel_b_i),
        .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i), .res_o(res_o), .vld_o(vld_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] m_res [N];
    logic         m_vld [N];

    function automatic logic [W-1:0] f_op(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
        case (op)
            3'd0: return a;
            3'd1: return a + b;
            3'd2: return a - b;
            3'd3: return a & b;
            3'd4: return a | b;
            3'd5: return a ^ b;
            3'd6: return a << b[4:0];
            default: return a >> b[4:0];
        endcase
    endfunction

    function automatic logic [W-1:0] f_src(logic [1:0] s, logic [W-1:0] r, logic [W-1:0] i, logic [W-1:0] p);
        case (s)
            2'd0: return r;
            2'd1: return i;
            2'd2: return p;
            default: return '0;
        endcase
    endfunction

    task automatic cmp(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // apply current inputs for one edge, update model, compare at negedge
    task automatic step(string tag);
        logic [W-1:0] prev = '0;
        for (int k = 0; k < N; k++) begin
            logic [W-1:0] a = f_src(t_sa[k], t_ra[k], t_im[k], prev);
            logic [W-1:0] b = f_src(t_sb[k], t_rb[k], t_im[k], prev);
            logic [W-1:0] y = f_op(t_op[k], a, b);
            prev = y;
            if (stall_i) m_vld[k] = 1'b0;
            else begin
                m_vld[k] = t_en[k];
                if (t_en[k]) m_res[k] = y;
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            cmp($sformatf("%s stage%0d res", tag, k), res_o[W*k +: W], m_res[k]);
            cmp($sformatf("%s stage%0d vld", tag, k), W'(vld_o[k]), W'(m_vld[k]));
        end
    endtask

    task automatic set_stage(int k, logic en, logic [2:0] op, logic [1:0] sa, logic [1:0] sb,
                             logic [W-1:0] ra, logic [W-1:0] rb, logic [W-1:0] im);
        t_en[k] = en; t_op[k] = op; t_sa[k] = sa; t_sb[k] = sb;
        t_ra[k] = ra; t_rb[k] = rb; t_im[k] = im;
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        for (int k = 0; k < N; k++) begin
            set_stage(k, 1'b1, 3'd1, 2'd0, 2'd0, 32'hFFFF_FFFF, 32'h1, 32'h0);
            m_res[k] = '0; m_vld[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state, even with all stages enabled
        for (int k = 0; k < N; k++) begin
            cmp("R1 reset res", res_o[W*k +: W], '0);
            cmp("R1 reset vld", W'(vld_o[k]), '0);
        end
        rst_n = 1'b1;

        // R3: every opcode, wrap and 5-bit shift truncation; R9 lanes
        set_stage(0, 1, 3'd1, 2'd0, 2'd0, 32'hFFFF_FFFF, 32'h2, 32'h0);
        set_stage(1, 1, 3'd2, 2'd0, 2'd1, 32'h0, 32'h0, 32'h1);
        set_stage(2, 1, 3'd6, 2'd0, 2'd1, 32'h8000_0001, 32'h0, 32'd33);
        step("R3 add/sub wrap shl");
        cmp("R3 add wraps", res_o[31:0], 32'h1);
        cmp("R3 sub wraps", res_o[63:32], 32'hFFFF_FFFF);
        cmp("R3 shl by 33 uses 1", res_o[95:64], 32'h2);
        set_stage(0, 1, 3'd3, 2'd0, 2'd0, 32'hF0F0_1234, 32'hFF00_FF00, 0);
        set_stage(1, 1, 3'd4, 2'd0, 2'd0, 32'h0F00_0001, 32'h0000_1000, 0);
        set_stage(2, 1, 3'd7, 2'd0, 2'd0, 32'h8000_0000, 32'd31, 0);
        step("R3 and/or/shr");
        cmp("R3 shr logical", res_o[95:64], 32'h1);
        set_stage(0, 1, 3'd5, 2'd1, 2'd0, 32'h0, 32'hAAAA_5555, 32'hFFFF_0000);
        set_stage(1, 1, 3'd0, 2'd1, 2'd0, 32'h1, 32'h2, 32'hCAFE_F00D);
        set_stage(2, 1, 3'd1, 2'd3, 2'd0, 32'h5, 32'h7, 32'h9);
        step("R4 xor/pass/zero-select");
        cmp("R4 zero select", res_o[95:64], 32'h7);

        // R4: stage 0 chain select yields zero
        set_stage(0, 1, 3'd1, 2'd2, 2'd1, 32'h11, 32'h22, 32'h33);
        step("R4 stage0 prev is zero");
        cmp("R4 stage0 prev", res_o[31:0], 32'h33);

        // R5: s ^ ((a << 3) & b) in one cycle
        set_stage(0, 1, 3'd6, 2'd0, 2'd1, 32'h1234_5678, 32'h0, 32'd3);
        set_stage(1, 1, 3'd3, 2'd2, 2'd0, 32'h0, 32'h0FF0_FFF0, 32'h0);
        set_stage(2, 1, 3'd5, 2'd0, 2'd2, 32'hDEAD_BEEF, 32'h0, 32'h0);
        step("R5 cascade");
        cmp("R5 cascade expr", res_o[95:64],
            32'hDEAD_BEEF ^ ((32'h1234_5678 << 3) & 32'h0FF0_FFF0));

        // R6: disabled stage holds; R8: chain through disabled stage
        set_stage(0, 0, 3'd1, 2'd0, 2'd0, 32'h100, 32'h23, 0);
        set_stage(1, 1, 3'd1, 2'd2, 2'd1, 0, 0, 32'h1);
        set_stage(2, 0, 3'd0, 2'd0, 2'd0, 32'h9, 0, 0);
        step("R6 R8 disabled");
        cmp("R8 chain from disabled", res_o[63:32], 32'h124);
        cmp("R6 held stage2", res_o[95:64],
            32'hDEAD_BEEF ^ ((32'h1234_5678 << 3) & 32'h0FF0_FFF0));

        // R7: stall drops a full configuration
        stall_i = 1'b1;
        for (int k = 0; k < N; k++) set_stage(k, 1, 3'd4, 2'd1, 2'd1, 0, 0, 32'hFFFF_FFFF);
        step("R7 stall");
        step("R7 stall second cycle");
        stall_i = 1'b0;
        for (int k = 0; k < N; k++) t_en[k] = 1'b0;
        step("R7 after stall nothing leaked");

        // R2 R9: constrained random mix
        for (int i = 0; i < 1500; i++) begin
            stall_i = ($urandom_range(0, 9) == 0);
            for (int k = 0; k < N; k++) begin
                logic [W-1:0] sm;
                sm = ($urandom_range(0, 3) == 0) ? W'($urandom_range(0, 40)) : W'($urandom);
                set_stage(k, logic'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
                          2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                          $urandom, sm, $urandom);
            end
            step("R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule